// File: doc/BRIEF.md
# Dual Bitstream Output Multiplexer

This block sits between two 1-bit sigma-delta modulators, one for line current and one for line voltage, and the two output pads of a measurement front end: a true pad and a complementary pad. It registers both streams, plus a small set of per-channel diagnostic signals, on the rising clock edge. It then decides what each pad carries. The choices are the raw streams, their inverses, a single-pin interleave of both streams, or one of the diagnostic signals.

Two configuration sources are supported. In pin mode a 2-bit strap code picks one of four fixed routings and also tells the voltage channel whether to run. In register mode three fields control the routing: a voltage power-down bit, a multiplex-enable bit and a test-select field. The test-select field can hand either pad, or both, to an internal diagnostic signal. When only one pad is taken over, the other pad keeps its normal routing. In the interleaved routing the true pad shows the current bit while the clock is low and the voltage bit while the clock is high.

Top module: `bitstream_pin_mux`

## Requirements
- R1: While reset is asserted, every registered stream bit is 0, so in pin code 0 the true pad reads 0 and the complementary pad reads 1 in both clock phases.
- R2: In an interleaved routing, the true pad carries the registered current bit during the low clock phase and the registered voltage bit during the high clock phase.
- R3: In the interleaved routing of pin code 0, the complementary pad is always the inverse of the true pad.
- R4: Pin code 0 selects the interleaved routing and drives the voltage-enable output high.
- R5: Pin codes 1 and 2 drive voltage-enable low, put the current stream on the true pad and put its inverse on the complementary pad.
- R6: Pin code 3 puts the voltage stream on the true pad and the current stream on the complementary pad, with voltage-enable high.
- R7: In register mode with test-select[5:4]=00, power-down=1 gives the current stream and its inverse with voltage-enable low. Otherwise, multiplex=0 gives voltage on the true pad and current on the complementary pad, and multiplex=1 gives the interleave and its inverse.
- R8: In register mode with test-select[5:4]=01, the complementary pad carries current diagnostic index test-select[1:0], and the true pad follows the R7 rule. The index codes are 0 = slow chopper, 1 = fast chopper, 2 = self-test level, 3 = pseudo-random dither.
- R9: In register mode with test-select[5:4]=10, the true pad carries voltage diagnostic index test-select[3:2], using the R8 index codes, and the complementary pad follows the R7 rule.
- R10: In register mode with test-select[5:4]=11, the true pad carries voltage diagnostic test-select[3:2] and the complementary pad carries current diagnostic test-select[1:0].
- R11: A change on a stream input reaches a pad only after the next rising clock edge, never within the current phase.
- R12: Register mode ignores the pin code, and pin mode ignores power-down, multiplex and test-select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Modulator clock; its level also selects the interleave phase |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_mode_i | input | 1 | 1 = register mode, 0 = pin mode |
| pin_code_i | input | 2 | Strap routing code used in pin mode |
| vpd_i | input | 1 | Voltage power-down, register mode |
| mux_en_i | input | 1 | Interleave enable, register mode |
| tsel_i | input | 2*log2(DIAG_N)+2 | Test-select field, register mode |
| cur_bit_i | input | 1 | Current-channel sigma-delta bit |
| volt_bit_i | input | 1 | Voltage-channel sigma-delta bit |
| cur_diag_i | input | DIAG_N | Current-channel diagnostic signals |
| volt_diag_i | input | DIAG_N | Voltage-channel diagnostic signals |
| out_p_o | output | 1 | True output pad |
| out_n_o | output | 1 | Complementary output pad |
| volt_en_o | output | 1 | Voltage channel run enable |

## Verification
The bench builds the block with its defaults: four diagnostic signals per channel, a 6-bit test-select field, one input register stage and a two-flop reset release. With these settings every index value of both diagnostic selectors is reachable. The one-edge latency also lets each vector be checked in both clock phases of a single cycle, which is what exposes the interleave ordering. Mid-phase input changes and the reset level are then covered by directed steps.

// File: rtl/bsmux_pkg.sv
package bsmux_pkg;
  typedef enum logic [2:0] {
    SRC_VOLT,
    SRC_CUR,
    SRC_CUR_N,
    SRC_MIX,
    SRC_MIX_N,
    SRC_VDIAG,
    SRC_CDIAG
  } src_e;

  typedef struct packed {
    src_e p_src;
    src_e n_src;
    logic volt_en;
  } route_t;
endpackage

// File: rtl/bsm_rst_sync.sv
module bsm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/bsm_pipe.sv
module bsm_pipe #(
  parameter int W      = 2,
  parameter int STAGES = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] stage_in;
    logic [W-1:0] stage_nxt;
    if (s == 0) begin : g_first
      assign stage_in = d;
    end else begin : g_rest
      assign stage_in = stage_q[s-1];
    end
    always_comb begin
      stage_nxt = en ? stage_in : stage_q[s];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_nxt;
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/bsm_route_dec.sv
module bsm_route_dec
  import bsmux_pkg::*;
#(
  parameter int IDX_W = 2,
  localparam int TS_W = 2 * IDX_W + 2
) (
  input  logic             soft_mode,
  input  logic [1:0]       pin_code,
  input  logic             vpd,
  input  logic             mux_en,
  input  logic [TS_W-1:0]  tsel,
  output route_t           route,
  output logic [IDX_W-1:0] p_idx,
  output logic [IDX_W-1:0] n_idx
);
  logic [1:0] grp;
  route_t     base;

  assign grp   = tsel[TS_W-1 -: 2];
  assign p_idx = tsel[2*IDX_W-1 -: IDX_W];
  assign n_idx = tsel[IDX_W-1:0];

  // normal routing, before any diagnostic override
  always_comb begin
    base = '{p_src: SRC_VOLT, n_src: SRC_CUR, volt_en: 1'b1};
    if (!soft_mode) begin
      unique case (pin_code)
        2'd0:       base = '{p_src: SRC_MIX,  n_src: SRC_MIX_N, volt_en: 1'b1};
        2'd1, 2'd2: base = '{p_src: SRC_CUR,  n_src: SRC_CUR_N, volt_en: 1'b0};
        default:    base = '{p_src: SRC_VOLT, n_src: SRC_CUR,   volt_en: 1'b1};
      endcase
    end else if (vpd) begin
      base = '{p_src: SRC_CUR, n_src: SRC_CUR_N, volt_en: 1'b0};
    end else if (mux_en) begin
      base = '{p_src: SRC_MIX, n_src: SRC_MIX_N, volt_en: 1'b1};
    end
  end

  // diagnostic override, register mode only
  always_comb begin
    route = base;
    if (soft_mode) begin
      unique case (grp)
        2'b01:   route.n_src = SRC_CDIAG;
        2'b10:   route.p_src = SRC_VDIAG;
        2'b11: begin
          route.p_src = SRC_VDIAG;
          route.n_src = SRC_CDIAG;
        end
        default: route = base;
      endcase
    end
  end
endmodule

// File: rtl/bsm_out_sel.sv
module bsm_out_sel
  import bsmux_pkg::*;
#(
  parameter int DIAG_N = 4,
  localparam int IDX_W = $clog2(DIAG_N)
) (
  input  src_e              src,
  input  logic [IDX_W-1:0]  idx,
  input  logic              cur_bit,
  input  logic              volt_bit,
  input  logic              mix_bit,
  input  logic [DIAG_N-1:0] cur_diag,
  input  logic [DIAG_N-1:0] volt_diag,
  output logic              pad_bit
);
  always_comb begin
    unique case (src)
      SRC_VOLT:  pad_bit = volt_bit;
      SRC_CUR:   pad_bit = cur_bit;
      SRC_CUR_N: pad_bit = ~cur_bit;
      SRC_MIX:   pad_bit = mix_bit;
      SRC_MIX_N: pad_bit = ~mix_bit;
      SRC_VDIAG: pad_bit = volt_diag[idx];
      SRC_CDIAG: pad_bit = cur_diag[idx];
      default:   pad_bit = 1'b0;
    endcase
  end
endmodule

// File: rtl/bitstream_pin_mux.sv
module bitstream_pin_mux
  import bsmux_pkg::*;
#(
  parameter int DIAG_N     = 4,
  parameter int STAGES     = 1,
  parameter int RST_STAGES = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           soft_mode_i,
  input  logic [1:0]                     pin_code_i,
  input  logic                           vpd_i,
  input  logic                           mux_en_i,
  input  logic [2*$clog2(DIAG_N)+1:0]    tsel_i,
  input  logic                           cur_bit_i,
  input  logic                           volt_bit_i,
  input  logic [DIAG_N-1:0]              cur_diag_i,
  input  logic [DIAG_N-1:0]              volt_diag_i,
  output logic                           out_p_o,
  output logic                           out_n_o,
  output logic                           volt_en_o
);
  localparam int IDX_W = $clog2(DIAG_N);
  localparam int PW    = 2 + 2 * DIAG_N;

  logic              rst_int_n;
  logic [PW-1:0]     pipe_d;
  logic [PW-1:0]     pipe_q;
  logic              cur_q;
  logic              volt_q;
  logic [DIAG_N-1:0] cdiag_q;
  logic [DIAG_N-1:0] vdiag_q;
  logic              mix_bit;
  route_t            route;
  logic [IDX_W-1:0]  p_idx;
  logic [IDX_W-1:0]  n_idx;

  bsm_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  assign pipe_d = {cur_bit_i, volt_bit_i, cur_diag_i, volt_diag_i};

  bsm_pipe #(.W(PW), .STAGES(STAGES)) u_pipe (
    .clk   (clk),
    .rst_n (rst_int_n),
    .en    (1'b1),
    .d     (pipe_d),
    .q     (pipe_q)
  );

  assign {cur_q, volt_q, cdiag_q, vdiag_q} = pipe_q;

  // low phase shows current, high phase shows voltage
  assign mix_bit = clk ? volt_q : cur_q;

  bsm_route_dec #(.IDX_W(IDX_W)) u_dec (
    .soft_mode (soft_mode_i),
    .pin_code  (pin_code_i),
    .vpd       (vpd_i),
    .mux_en    (mux_en_i),
    .tsel      (tsel_i),
    .route     (route),
    .p_idx     (p_idx),
    .n_idx     (n_idx)
  );

  bsm_out_sel #(.DIAG_N(DIAG_N)) u_sel_p (
    .src       (route.p_src),
    .idx       (p_idx),
    .cur_bit   (cur_q),
    .volt_bit  (volt_q),
    .mix_bit   (mix_bit),
    .cur_diag  (cdiag_q),
    .volt_diag (vdiag_q),
    .pad_bit   (out_p_o)
  );

  bsm_out_sel #(.DIAG_N(DIAG_N)) u_sel_n (
    .src       (route.n_src),
    .idx       (n_idx),
    .cur_bit   (cur_q),
    .volt_bit  (volt_q),
    .mix_bit   (mix_bit),
    .cur_diag  (cdiag_q),
    .volt_diag (vdiag_q),
    .pad_bit   (out_n_o)
  );

  assign volt_en_o = route.volt_en;
endmodule

// File: rtl/bitstream_pin_mux_chk.sv
module bitstream_pin_mux_chk #(
  parameter int DIAG_N     = 4,
  parameter int STAGES     = 1,
  parameter int RST_STAGES = 2
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        soft_mode_i,
  input logic [1:0]                  pin_code_i,
  input logic                        vpd_i,
  input logic                        mux_en_i,
  input logic [2*$clog2(DIAG_N)+1:0] tsel_i,
  input logic                        cur_bit_i,
  input logic                        volt_bit_i,
  input logic [DIAG_N-1:0]           cur_diag_i,
  input logic [DIAG_N-1:0]           volt_diag_i,
  input logic                        out_p_o,
  input logic                        out_n_o,
  input logic                        volt_en_o
);
  localparam int IDX_W = $clog2(DIAG_N);
  localparam int TS_W  = 2 * IDX_W + 2;
  localparam logic [3:0] WARM = 4'(STAGES + RST_STAGES + 1);

  logic [3:0]        warm_cnt;
  logic              warm;
  logic              cur_prev;
  logic [DIAG_N-1:0] vd_prev;
  logic              hard0;
  logic              hard3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               warm_cnt <= '0;
    else if (warm_cnt < WARM) warm_cnt <= warm_cnt + 4'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_prev <= 1'b0;
      vd_prev  <= '0;
    end else begin
      cur_prev <= cur_bit_i;
      vd_prev  <= volt_diag_i;
    end
  end

  assign warm  = (warm_cnt == WARM);
  assign hard0 = !soft_mode_i && (pin_code_i == 2'd0);
  assign hard3 = !soft_mode_i && (pin_code_i == 2'd3);

  assert_mix_complement_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hard0 |-> (out_n_o != out_p_o));

  assert_vchan_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_mode_i && (pin_code_i == 2'd1 || pin_code_i == 2'd2))
      |-> (!volt_en_o && (out_n_o != out_p_o)));

  if (STAGES == 1) begin : g_timed
    // sampled just before a rising edge, i.e. in the low phase
    assert_low_phase_current_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && hard0) |-> (out_p_o == cur_prev));

    assert_code3_current_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && hard3) |-> (out_n_o == cur_prev && volt_en_o));

    assert_vdiag_true_pad_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && soft_mode_i && tsel_i[TS_W-1 -: 2] == 2'b10)
        |-> (out_p_o == vd_prev[tsel_i[2*IDX_W-1 -: IDX_W]]));
  end
endmodule

bind bitstream_pin_mux bitstream_pin_mux_chk #(
  .DIAG_N(DIAG_N), .STAGES(STAGES), .RST_STAGES(RST_STAGES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_mode_i(soft_mode_i), .pin_code_i(pin_code_i),
  .vpd_i(vpd_i), .mux_en_i(mux_en_i), .tsel_i(tsel_i), .cur_bit_i(cur_bit_i),
  .volt_bit_i(volt_bit_i), .cur_diag_i(cur_diag_i), .volt_diag_i(volt_diag_i),
  .out_p_o(out_p_o), .out_n_o(out_n_o), .volt_en_o(volt_en_o)
);

// File: tb/bitstream_pin_mux_test.sv
`timescale 1ns/1ps
module bitstream_pin_mux_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       soft_mode_i, vpd_i, mux_en_i, cur_bit_i, volt_bit_i;
  logic [1:0] pin_code_i;
  logic [5:0] tsel_i;
  logic [3:0] cur_diag_i, volt_diag_i;
  logic       out_p_o, out_n_o, volt_en_o;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  bitstream_pin_mux uut (
    .clk(clk), .rst_n(rst_n), .soft_mode_i(soft_mode_i), .pin_code_i(pin_code_i),
    .vpd_i(vpd_i), .mux_en_i(mux_en_i), .tsel_i(tsel_i), .cur_bit_i(cur_bit_i),
    .volt_bit_i(volt_bit_i), .cur_diag_i(cur_diag_i), .volt_diag_i(volt_diag_i),
    .out_p_o(out_p_o), .out_n_o(out_n_o), .volt_en_o(volt_en_o)
  );

  // {soft, code, vpd, mux, tsel, cur, volt, cdiag, vdiag,
  //  exp{p_hi, n_hi, p_lo, n_lo, ven}, req}
  localparam int NV = 17;
  localparam logic [29:0] VEC [NV] = '{
    {1'b0, 2'd0, 1'b0, 1'b0, 6'h00, 1'b1, 1'b0, 4'h0, 4'h0, 5'b01101, 4'd2},  // R2 R3
    {1'b0, 2'd0, 1'b0, 1'b0, 6'h00, 1'b0, 1'b1, 4'h0, 4'h0, 5'b10011, 4'd2},  // R2 R3
    {1'b0, 2'd0, 1'b0, 1'b0, 6'h00, 1'b1, 1'b1, 4'h0, 4'h0, 5'b10101, 4'd4},  // R4
    {1'b0, 2'd1, 1'b0, 1'b0, 6'h00, 1'b1, 1'b0, 4'h0, 4'h0, 5'b10100, 4'd5},  // R5
    {1'b0, 2'd2, 1'b0, 1'b0, 6'h00, 1'b0, 1'b1, 4'h0, 4'h0, 5'b01010, 4'd5},  // R5
    {1'b0, 2'd3, 1'b0, 1'b0, 6'h00, 1'b1, 1'b0, 4'h0, 4'h0, 5'b01011, 4'd6},  // R6
    {1'b0, 2'd3, 1'b0, 1'b0, 6'h00, 1'b0, 1'b1, 4'h0, 4'h0, 5'b10101, 4'd6},  // R6
    {1'b1, 2'd0, 1'b0, 1'b0, 6'h00, 1'b1, 1'b0, 4'h0, 4'h0, 5'b01011, 4'd7},  // R7
    {1'b1, 2'd0, 1'b0, 1'b1, 6'h00, 1'b1, 1'b0, 4'h0, 4'h0, 5'b01101, 4'd7},  // R7
    {1'b1, 2'd0, 1'b1, 1'b1, 6'h00, 1'b0, 1'b1, 4'h0, 4'h0, 5'b01010, 4'd7},  // R7
    {1'b1, 2'd0, 1'b0, 1'b0, 6'h12, 1'b0, 1'b1, 4'h4, 4'h0, 5'b11111, 4'd8},  // R8
    {1'b1, 2'd0, 1'b0, 1'b0, 6'h13, 1'b0, 1'b0, 4'h7, 4'h0, 5'b00001, 4'd8},  // R8
    {1'b1, 2'd0, 1'b0, 1'b1, 6'h24, 1'b1, 1'b0, 4'h0, 4'h2, 5'b11101, 4'd9},  // R9
    {1'b1, 2'd0, 1'b0, 1'b0, 6'h3C, 1'b0, 1'b0, 4'h0, 4'h8, 5'b10101, 4'd10}, // R10
    {1'b1, 2'd0, 1'b0, 1'b0, 6'h31, 1'b0, 1'b0, 4'h2, 4'h1, 5'b11111, 4'd10}, // R10
    {1'b1, 2'd1, 1'b0, 1'b0, 6'h00, 1'b0, 1'b1, 4'h0, 4'h0, 5'b10101, 4'd12}, // R12
    {1'b0, 2'd3, 1'b1, 1'b1, 6'h3F, 1'b0, 1'b1, 4'hF, 4'hF, 5'b10101, 4'd12}  // R12
  };

  task automatic check(input string req, input logic [4:0] got, input logic [4:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %b expected %b", req, got, exp);
    end
  endtask

  task automatic apply(input logic [29:0] v);
    {soft_mode_i, pin_code_i, vpd_i, mux_en_i, tsel_i, cur_bit_i, volt_bit_i,
     cur_diag_i, volt_diag_i} = v[29:9];
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [4:0] got;
    rst_n = 1'b0;
    apply({1'b0, 2'd0, 1'b0, 1'b0, 6'h00, 1'b1, 1'b1, 4'hF, 4'hF, 9'd0});
    // R1: reset level in both phases
    @(posedge clk); #2;
    check("R1", {out_p_o, out_n_o, 3'b0}, 5'b01000);
    @(negedge clk); #2;
    check("R1", {out_p_o, out_n_o, 3'b0}, 5'b01000);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #3;
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      @(posedge clk); #2;
      got[4] = out_p_o; got[3] = out_n_o;
      @(negedge clk); #2;
      got[2] = out_p_o; got[1] = out_n_o; got[0] = volt_en_o;
      check($sformatf("R%0d vec %0d", VEC[i][3:0], i), got, VEC[i][8:4]);
      #1;
    end
    // R11: mid-phase input change held until next rising edge
    apply({1'b0, 2'd3, 1'b0, 1'b0, 6'h00, 1'b0, 1'b0, 4'h0, 4'h0, 9'd0});
    @(posedge clk); @(negedge clk); #1;
    volt_bit_i = 1'b1;
    #1;
    check("R11 low phase", {out_p_o, 4'b0}, 5'b00000);
    @(posedge clk); #2;
    check("R11 high phase", {out_p_o, 4'b0}, 5'b10000);
    @(negedge clk); #1;
    volt_bit_i = 1'b0;
    #1;
    check("R11 hold", {out_p_o, 4'b0}, 5'b10000);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule